// File: doc/BRIEF.md
# Identifier Search Triplet Unit

This unit carries out a single step of the bus-wide search that walks the identifiers of the attached devices. A caller pulses a start input and gives a preferred direction. The unit then asks a bit-slot engine for two read slots. The first read returns the identifier bit at the current search position, and the second returns its complement. The unit then decides which branch of the search tree to follow. Unless the step has failed, it asks the slot engine for one more slot, a write slot that sends the chosen direction back to the devices.

The outcome is reported as a 3-bit code together with a one-cycle done pulse. The caller keeps the search path and the record of discrepancy positions, and it calls the unit once for every bit position. The slot engine is driven through a level request that is held until the engine acknowledges it. The request carries a read/write kind and a write bit. The engine returns the sampled bus level with its acknowledge.

Top module: `triplet_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `step_done` and `slot_req` are 0 and `step_res` is 3'b000.
- R2: An accepted step issues its slots in a fixed order. The first slot is a read (`slot_wr`=0) giving the identifier bit, the second is a read giving the complement bit, and the optional third is a write (`slot_wr`=1).
- R3: The result code carries the identifier bit in bit 0, the complement bit in bit 1 and the direction taken in bit 2.
- R4: When both read bits are 1, no write slot is issued. `step_done` rises the cycle after the second read is acknowledged, with `step_res` = 3'b011.
- R5: When both read bits are 0, the direction is the preferred direction, so the result is 3'b100 or 3'b000.
- R6: When exactly one read bit is 1, the direction equals the identifier bit, so the result is 3'b101 (identifier 1) or 3'b010 (identifier 0).
- R7: In the non-error cases a write slot carrying the chosen direction on `slot_wdata` follows the second read. `step_done` rises the cycle after that write is acknowledged.
- R8: The preferred direction is sampled in the cycle the step is accepted. Changes to `pref_dir` after that cycle do not affect the step.
- R9: `busy` is high from the cycle after acceptance until the step ends. A `step_go` pulse while busy is ignored and starts no extra slots.
- R10: `step_res` changes only together with a `step_done` pulse. It holds its value between steps.
- R11: `step_done` is a single-cycle pulse.
- R12: A slot request stays high, with unchanged `slot_wr` and `slot_wdata`, until `slot_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_go | input | 1 | Start one search step (accepted only when idle) |
| pref_dir | input | 1 | Direction to take when both read bits are 0 |
| busy | output | 1 | A step is in progress |
| step_done | output | 1 | One-cycle pulse: step finished, result valid |
| step_res | output | 3 | {direction, complement bit, identifier bit}, or 3'b011 on error |
| slot_req | output | 1 | Slot request, held until acknowledged |
| slot_wr | output | 1 | 0 = read slot, 1 = write slot |
| slot_wdata | output | 1 | Bit to send in a write slot |
| slot_ack | input | 1 | Slot engine finished the requested slot |
| slot_rbit | input | 1 | Bus level sampled in a read slot, valid with `slot_ack` |

## Verification
The bench runs every combination of identifier bit, complement bit and preferred direction, so all four decision branches are covered. Swapping the two one-hot read patterns tells the identifier bit apart from the complement in the packing. Both preferred values are tried against the both-zero pattern, which shows whether the direction comes from the preference or from the read bits. Each combination is repeated with acknowledge delays of 0, 1 and 3 cycles. Each is also repeated with the preference flipped and `step_go` pulsed again mid-step. These variants separate sampling at acceptance from late sampling, and they show whether the request is held correctly while the engine is slow.

// File: rtl/triplet_pkg.sv
package triplet_pkg;

  localparam int RES_W = 3;

  typedef logic [RES_W-1:0] tres_t;

  typedef enum logic [1:0] {
    TS_IDLE,
    TS_RD_ID,
    TS_RD_CMP,
    TS_WR_DIR
  } tseq_e;

  // Both devices answer 1 on both reads: nobody present or bus fault.
  function automatic logic is_dead(input logic id_b, input logic cmp_b);
    return id_b & cmp_b;
  endfunction

  // Branch choice: equal reads (both 0) mean a discrepancy -> take preference.
  function automatic logic pick_dir(input logic id_b, input logic cmp_b,
                                    input logic pref_b);
    return (id_b == cmp_b) ? pref_b : id_b;
  endfunction

  function automatic tres_t pack_res(input logic id_b, input logic cmp_b,
                                     input logic dir_b);
    tres_t r;
    if (is_dead(id_b, cmp_b)) r = 3'b011;
    else                      r = {dir_b, cmp_b, id_b};
    return r;
  endfunction

endpackage

// File: rtl/trip_seq.sv
module trip_seq
  import triplet_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic slot_ack,
  input  logic cmp_dead,
  output logic slot_req,
  output logic slot_wr,
  output logic busy,
  output logic go_accept,
  output logic id_ack,
  output logic cmp_ack,
  output logic wr_ack,
  output logic fin
);

  tseq_e state_q, state_d;

  assign go_accept = go && (state_q == TS_IDLE);
  assign id_ack    = slot_ack && (state_q == TS_RD_ID);
  assign cmp_ack   = slot_ack && (state_q == TS_RD_CMP);
  assign wr_ack    = slot_ack && (state_q == TS_WR_DIR);
  assign fin       = (cmp_ack && cmp_dead) || wr_ack;

  assign slot_req  = (state_q != TS_IDLE);
  assign slot_wr   = (state_q == TS_WR_DIR);
  assign busy      = (state_q != TS_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_IDLE:   if (go_accept) state_d = TS_RD_ID;
      TS_RD_ID:  if (id_ack)    state_d = TS_RD_CMP;
      TS_RD_CMP: if (cmp_ack)   state_d = cmp_dead ? TS_IDLE : TS_WR_DIR;
      TS_WR_DIR: if (wr_ack)    state_d = TS_IDLE;
      default:                  state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TS_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/trip_capture.sv
module trip_capture
  import triplet_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go_accept,
  input  logic  pref_in,
  input  logic  id_ack,
  input  logic  cmp_ack,
  input  logic  rbit,
  input  logic  fin,
  output logic  pref_q,
  output logic  id_q,
  output logic  cmp_q,
  output logic  dir,
  output tres_t res_q,
  output logic  done_q
);

  logic cmp_now;
  logic dir_now;

  assign cmp_now = cmp_ack ? rbit : cmp_q;
  assign dir_now = pick_dir(id_q, cmp_now, pref_q);
  assign dir     = pick_dir(id_q, cmp_q, pref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pref_q <= 1'b0;
      id_q   <= 1'b0;
      cmp_q  <= 1'b0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (go_accept) pref_q <= pref_in;
      if (id_ack)    id_q   <= rbit;
      if (cmp_ack)   cmp_q  <= rbit;
      if (fin)       res_q  <= pack_res(id_q, cmp_now, dir_now);
      done_q <= fin;
    end
  end

endmodule

// File: rtl/triplet_unit.sv
module triplet_unit
  import triplet_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_go,
  input  logic         pref_dir,
  output logic         busy,
  output logic         step_done,
  output logic [2:0]   step_res,
  output logic         slot_req,
  output logic         slot_wr,
  output logic         slot_wdata,
  input  logic         slot_ack,
  input  logic         slot_rbit
);

  // Named internal events, also used by the bound checker.
  logic go_accept;
  logic id_ack;
  logic cmp_ack;
  logic wr_ack;
  logic fin;
  logic cmp_dead;
  logic pref_q;
  logic id_q;
  logic cmp_q;
  logic dir;
  tres_t res_q;

  assign cmp_dead = is_dead(id_q, slot_rbit);

  trip_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (step_go),
    .slot_ack  (slot_ack),
    .cmp_dead  (cmp_dead),
    .slot_req  (slot_req),
    .slot_wr   (slot_wr),
    .busy      (busy),
    .go_accept (go_accept),
    .id_ack    (id_ack),
    .cmp_ack   (cmp_ack),
    .wr_ack    (wr_ack),
    .fin       (fin)
  );

  trip_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_accept (go_accept),
    .pref_in   (pref_dir),
    .id_ack    (id_ack),
    .cmp_ack   (cmp_ack),
    .rbit      (slot_rbit),
    .fin       (fin),
    .pref_q    (pref_q),
    .id_q      (id_q),
    .cmp_q     (cmp_q),
    .dir       (dir),
    .res_q     (res_q),
    .done_q    (step_done)
  );

  assign step_res   = res_q;
  assign slot_wdata = dir;

endmodule

// File: rtl/triplet_unit_chk.sv
module triplet_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       step_done,
  input logic [2:0] step_res,
  input logic       slot_req,
  input logic       slot_wr,
  input logic       slot_wdata,
  input logic       slot_ack,
  input logic       slot_rbit,
  input logic       go_accept,
  input logic       cmp_ack,
  input logic       wr_ack,
  input logic       id_q,
  input logic       cmp_q,
  input logic       pref_q
);

  p_first_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go_accept |=> slot_req && !slot_wr);

  p_dead_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ack && id_q && slot_rbit |=> step_done && !slot_req && step_res == 3'b011);

  p_clash_pref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack && !id_q && !cmp_q |-> slot_wdata == pref_q);

  p_one_hot_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack && (id_q != cmp_q) |-> slot_wdata == id_q);

  p_write_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ack && !(id_q && slot_rbit) |=> slot_req && slot_wr);

  p_write_report_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> step_done && step_res[2] == $past(slot_wdata));

  p_no_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !go_accept);

  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step_done |-> $stable(step_res));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && !slot_ack |=> slot_req && $stable(slot_wr) && $stable(slot_wdata));

endmodule

bind triplet_unit triplet_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .step_done  (step_done),
  .step_res   (step_res),
  .slot_req   (slot_req),
  .slot_wr    (slot_wr),
  .slot_wdata (slot_wdata),
  .slot_ack   (slot_ack),
  .slot_rbit  (slot_rbit),
  .go_accept  (go_accept),
  .cmp_ack    (cmp_ack),
  .wr_ack     (wr_ack),
  .id_q       (id_q),
  .cmp_q      (cmp_q),
  .pref_q     (pref_q)
);

// File: tb/triplet_unit_test.sv
module triplet_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_go = 1'b0;
  logic       pref_dir = 1'b0;
  logic       busy;
  logic       step_done;
  logic [2:0] step_res;
  logic       slot_req;
  logic       slot_wr;
  logic       slot_wdata;
  logic       slot_ack = 1'b0;
  logic       slot_rbit = 1'b0;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  triplet_unit uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_go    (step_go),
    .pref_dir   (pref_dir),
    .busy       (busy),
    .step_done  (step_done),
    .step_res   (step_res),
    .slot_req   (slot_req),
    .slot_wr    (slot_wr),
    .slot_wdata (slot_wdata),
    .slot_ack   (slot_ack),
    .slot_rbit  (slot_rbit)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_step(input bit id, input bit cmp, input bit pref,
                          input int dly, input bit wiggle);
    int  nslots;
    bit  kinds [3];
    bit  wbit;
    bit  dead;
    bit  exp_dir;
    int  exp_res;
    int  exp_slots;
    bit  got_done;
    logic [2:0] held;
    dead      = id && cmp;
    exp_dir   = (id || cmp) ? id : pref;
    exp_res   = dead ? 3 : (exp_dir * 4 + cmp * 2 + id);
    exp_slots = dead ? 2 : 3;
    nslots    = 0;
    got_done  = 1'b0;
    wbit      = 1'b0;
    kinds     = '{default: 1'b0};

    @(negedge clk);
    step_go  = 1'b1;
    pref_dir = pref;
    @(negedge clk);
    step_go = 1'b0;
    check("R9 busy after accept", busy, 1);
    if (wiggle) pref_dir = ~pref;       // R8: late change must not matter
    for (int k = 0; k < 60; k++) begin
      if (step_done) begin
        got_done = 1'b1;
        break;
      end
      if (wiggle && k == 1) step_go = 1'b1;  // R9: ignored while busy
      else step_go = 1'b0;
      if (slot_req) begin
        if (nslots < 3) kinds[nslots] = slot_wr;
        if (slot_wr) wbit = slot_wdata;
        for (int w = 0; w < dly; w++) begin
          @(negedge clk);
          step_go = 1'b0;
          check("R12 request held", slot_req, 1);
          if (nslots < 3) check("R12 kind stable", slot_wr, kinds[nslots]);
        end
        slot_ack  = 1'b1;
        slot_rbit = (nslots == 0) ? id : cmp;
        @(negedge clk);
        step_go   = 1'b0;
        slot_ack  = 1'b0;
        slot_rbit = 1'b0;
        nslots++;
      end else begin
        @(negedge clk);
      end
    end
    step_go = 1'b0;
    check("R11 done seen", got_done, 1);
    check("R2 slot count / R4 no write on error", nslots, exp_slots);
    check("R2 first slot is read", kinds[0], 0);
    check("R2 second slot is read", kinds[1], 0);
    if (!dead) begin
      check("R2 third slot is write", kinds[2], 1);
      check("R7 written direction", wbit, exp_dir);
    end
    if (dead)            check("R4 error code", step_res, exp_res);
    else if (!id && !cmp) check("R5 preferred direction result", step_res, exp_res);
    else                 check("R6 single-one result", step_res, exp_res);
    check("R3 bit0 is identifier", step_res[0], id);
    check("R3 bit1 is complement", step_res[1], cmp);
    held = step_res;
    @(negedge clk);
    check("R11 done is one cycle", step_done, 0);
    pref_dir = ~pref_dir;
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      check("R10 result held", step_res, held);
      check("R9 no extra step", slot_req, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", step_done, 0);
    check("R1 req", slot_req, 0);
    check("R1 result", step_res, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int wg = 0; wg < 2; wg++)
      for (int d = 0; d < 3; d++)
        for (int c = 0; c < 8; c++)
          run_step(c[0], c[1], c[2], (d == 2) ? 3 : d, wg[0]);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule